// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the data side of a 32-bit processor that spends several clock cycles on each instruction. A single ALU and a single memory port are reused from cycle to cycle. Values that one cycle produces and a later cycle needs are held in internal registers: the program counter, the instruction register, the memory data register, the two operand latches A and B, the ALU result latch, the exception program counter and the cause register.

The block contains no sequencing of its own. An external controller drives one strobe or select per datapath function in every cycle. The block returns the opcode and function fields of the held instruction, the ALU zero flag and a signed overflow flag, so that the controller can pick its next step. Instructions and data share one word-addressed memory inside the block. The memory has a side write port so that a program can be loaded before execution starts.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter holds `RESET_PC` (default 0). The ALU result latch, EPC, cause and all 32 general registers hold zero.
- R2: The memory byte address is the program counter when `i_or_d`=0 and the ALU result latch when `i_or_d`=1. The word used is byte-address bits [MAW+1:2], so addresses wrap modulo the memory size. `mem_rdata` shows that word in the same cycle. A high `pre_we` writes `pre_wdata` to word `pre_addr` at the clock edge.
- R3: The instruction register loads the memory word at an edge where `ir_wr` is high, and holds at every other edge. `opcode` is IR[31:26] and `funct` is IR[5:0]. The memory data register loads the memory word at an edge where `mem_rd` is high.
- R4: The first ALU operand is the PC when `alu_src_a`=0 and latch A when it is 1. The second operand is selected by `alu_src_b`: 00 gives latch B, 01 gives the constant 4, 10 gives the sign-extended IR[15:0], and 11 gives that value shifted left by two.
- R5: `alu_op` 00 makes the ALU add and 01 makes it subtract. With 10 the operation follows `funct`: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other funct value, and `alu_op` 11, give add. `alu_zero` is high exactly when the ALU result is zero.
- R6: `alu_ovf` is high only when the operation is add or subtract and the signed result overflows.
- R7: At every edge the ALU result latch captures the ALU result. Latch A captures the register addressed by IR[25:21] and latch B captures the register addressed by IR[20:16].
- R8: The PC is written when `pc_wr` is high, or when `pc_wr_cond` is high and `alu_zero` is high. In every other cycle it holds.
- R9: `pc_src` chooses the next PC: 00 the live ALU result, 01 the ALU result latch, 10 the jump target {PC[31:28], IR[25:0], 00}, 11 the exception vector `EXC_VEC` (default 0x8000_0180).
- R10: When `reg_wr` is high, the register write takes effect at the closing edge. The destination is IR[20:16] when `reg_dst`=0 and IR[15:11] when it is 1. The data is the ALU result latch when `mem_to_reg`=0 and the memory data register when it is 1. Register 0 always reads as zero.
- R11: A high `mem_wr` stores latch B into the addressed memory word at the edge.
- R12: A high `epc_wr` loads EPC from the live ALU result. A high `cause_wr` loads the cause register with `int_cause` zero-extended (0 for an undefined instruction, 1 for overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_we | input | 1 | Program-load write strobe |
| pre_addr | input | MAW | Program-load word index |
| pre_wdata | input | 32 | Program-load data |
| i_or_d | input | 1 | Memory address from PC (0) or ALU latch (1) |
| mem_rd | input | 1 | Load memory data register |
| mem_wr | input | 1 | Store latch B to memory |
| ir_wr | input | 1 | Load instruction register |
| reg_dst | input | 1 | Write destination field select |
| mem_to_reg | input | 1 | Register write data select |
| reg_wr | input | 1 | Register file write enable |
| alu_src_a | input | 1 | First operand select |
| alu_src_b | input | 2 | Second operand select |
| alu_op | input | 2 | ALU operation class |
| pc_src | input | 2 | Next PC source |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when zero flag set |
| epc_wr | input | 1 | Load EPC |
| cause_wr | input | 1 | Load cause register |
| int_cause | input | 1 | Cause code to load |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU result is zero |
| alu_ovf | output | 1 | Signed overflow on add or subtract |
| pc_o | output | 32 | Program counter |
| aluout_o | output | 32 | ALU result latch |
| mem_rdata | output | 32 | Memory word at current address |
| epc_o | output | 32 | Exception program counter |
| cause_o | output | 32 | Cause register |

## Verification
Four properties are checked in every cycle: the PC holds unless one of its two write conditions is true, the instruction register holds without its strobe, an exception-vector write lands on the vector, and the cause register takes the code it was given. A fifth ties the overflow flag to add and subtract. Operand routing, immediate scaling, the jump target, branch resolution, load and store data paths and the register-zero rule can only be shown by the scenarios. The bench plays the role of the controller and runs a short program of loads, adds, a store, a taken branch, a not-taken branch, a jump and an overflow trap. After each step it compares the PC, the ALU latch and the memory read data with hand-derived values.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
   localparam int unsigned XLEN = 32;
   typedef logic [XLEN-1:0] word_t;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0,
      FN_SUB = 3'd1,
      FN_AND = 3'd2,
      FN_OR  = 3'd3,
      FN_SLT = 3'd4
   } alu_fn_e;

   localparam logic [5:0] FUNCT_ADD = 6'h20;
   localparam logic [5:0] FUNCT_SUB = 6'h22;
   localparam logic [5:0] FUNCT_AND = 6'h24;
   localparam logic [5:0] FUNCT_OR  = 6'h25;
   localparam logic [5:0] FUNCT_SLT = 6'h2A;

   localparam logic [1:0] AOP_ADD   = 2'b00;
   localparam logic [1:0] AOP_SUB   = 2'b01;
   localparam logic [1:0] AOP_FUNCT = 2'b10;

   localparam logic [1:0] SB_REG    = 2'b00;
   localparam logic [1:0] SB_FOUR   = 2'b01;
   localparam logic [1:0] SB_IMM    = 2'b10;
   localparam logic [1:0] SB_IMM_SH = 2'b11;

   localparam logic [1:0] PS_ALU = 2'b00;
   localparam logic [1:0] PS_OUT = 2'b01;
   localparam logic [1:0] PS_JMP = 2'b10;
   localparam logic [1:0] PS_VEC = 2'b11;

   localparam int unsigned REG_AW = 5;
endpackage

// File: rtl/mcdp_aluctl.sv
module mcdp_aluctl
   import mcdp_pkg::*;
(
   input  logic [1:0] alu_op,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);
   always_comb begin
      fn = FN_ADD;
      case (alu_op)
         AOP_ADD: fn = FN_ADD;
         AOP_SUB: fn = FN_SUB;
         AOP_FUNCT: begin
            case (funct)
               FUNCT_ADD: fn = FN_ADD;
               FUNCT_SUB: fn = FN_SUB;
               FUNCT_AND: fn = FN_AND;
               FUNCT_OR:  fn = FN_OR;
               FUNCT_SLT: fn = FN_SLT;
               default:   fn = FN_ADD;
            endcase
         end
         default: fn = FN_ADD;
      endcase
   end
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
   import mcdp_pkg::*;
(
   input  alu_fn_e fn,
   input  word_t   a,
   input  word_t   b,
   output word_t   y,
   output logic    zero,
   output logic    ovf
);
   localparam int unsigned MSB = XLEN - 1;

   word_t sum;
   word_t diff;
   logic  lt;
   logic  sum_ovf;
   logic  diff_ovf;

   always_comb begin
      sum      = a + b;
      diff     = a - b;
      lt       = $signed(a) < $signed(b);
      sum_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      diff_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
   end

   always_comb begin
      y   = sum;
      ovf = 1'b0;
      case (fn)
         FN_ADD: begin y = sum;  ovf = sum_ovf;  end
         FN_SUB: begin y = diff; ovf = diff_ovf; end
         FN_AND: y = a & b;
         FN_OR:  y = a | b;
         FN_SLT: y = {{(XLEN-1){1'b0}}, lt};
         default: y = sum;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
   import mcdp_pkg::*;
#(
   parameter  int unsigned AW   = 5,
   localparam int unsigned NREG = 1 << AW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  word_t         wd,
   output word_t         rd_a,
   output word_t         rd_b
);
   word_t q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign q[g] = '0;
      end else begin : g_store
         word_t r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               r <= '0;
            else if (we && (wa == AW'(g)))
               r <= wd;
         end
         assign q[g] = r;
      end
   end

   assign rd_a = q[ra_a];
   assign rd_b = q[ra_b];
endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem
   import mcdp_pkg::*;
#(
   parameter  int unsigned WORDS = 64,
   localparam int unsigned AW    = $clog2(WORDS)
)(
   input  logic          clk,
   input  logic          pre_we,
   input  logic [AW-1:0] pre_addr,
   input  word_t         pre_wdata,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  word_t         wdata,
   output word_t         rdata
);
   word_t m [WORDS];

   always_ff @(posedge clk) begin
      if (pre_we)
         m[pre_addr] <= pre_wdata;
      else if (we)
         m[addr] <= wdata;
   end

   assign rdata = m[addr];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mcdp_pkg::*;
#(
   parameter  int unsigned MEM_WORDS = 64,
   parameter  logic [31:0] RESET_PC  = 32'h0000_0000,
   parameter  logic [31:0] EXC_VEC   = 32'h8000_0180,
   localparam int unsigned MAW       = $clog2(MEM_WORDS)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_we,
   input  logic [MAW-1:0] pre_addr,
   input  logic [31:0]    pre_wdata,
   input  logic           i_or_d,
   input  logic           mem_rd,
   input  logic           mem_wr,
   input  logic           ir_wr,
   input  logic           reg_dst,
   input  logic           mem_to_reg,
   input  logic           reg_wr,
   input  logic           alu_src_a,
   input  logic [1:0]     alu_src_b,
   input  logic [1:0]     alu_op,
   input  logic [1:0]     pc_src,
   input  logic           pc_wr,
   input  logic           pc_wr_cond,
   input  logic           epc_wr,
   input  logic           cause_wr,
   input  logic           int_cause,
   output logic [5:0]     opcode,
   output logic [5:0]     funct,
   output logic           alu_zero,
   output logic           alu_ovf,
   output logic [31:0]    pc_o,
   output logic [31:0]    aluout_o,
   output logic [31:0]    mem_rdata,
   output logic [31:0]    epc_o,
   output logic [31:0]    cause_o
);
   localparam int unsigned IMM_W = 16;

   if (MEM_WORDS < 16 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two of at least 16");
   end
   if (EXC_VEC[1:0] != 2'b00 || RESET_PC[1:0] != 2'b00) begin : g_bad_align
      $error("RESET_PC and EXC_VEC must be word aligned");
   end

   word_t pc_r, ir_r, mdr_r, a_r, b_r, aluout_r, epc_r, cause_r;
   word_t mem_addr, mem_word, imm_sx, imm_sh, op_a, op_b, alu_y, jump_tgt, pc_next;
   word_t rf_a, rf_b, rf_wd;
   alu_fn_e alu_fn;
   logic [REG_AW-1:0] rf_wa;
   logic pc_en;
   logic addr_unused;

   // Shared memory port
   assign mem_addr    = i_or_d ? aluout_r : pc_r;
   assign addr_unused = ^{mem_addr[XLEN-1:MAW+2], mem_addr[1:0]};

   mcdp_mem #(.WORDS(MEM_WORDS)) u_mem (
      .clk       (clk),
      .pre_we    (pre_we),
      .pre_addr  (pre_addr),
      .pre_wdata (pre_wdata),
      .we        (mem_wr),
      .addr      (mem_addr[MAW+1:2]),
      .wdata     (b_r),
      .rdata     (mem_word)
   );

   // Register file
   assign rf_wa = reg_dst ? ir_r[15:11] : ir_r[20:16];
   assign rf_wd = mem_to_reg ? mdr_r : aluout_r;

   mcdp_regfile #(.AW(REG_AW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra_a  (ir_r[25:21]),
      .ra_b  (ir_r[20:16]),
      .we    (reg_wr),
      .wa    (rf_wa),
      .wd    (rf_wd),
      .rd_a  (rf_a),
      .rd_b  (rf_b)
   );

   // Operand selection
   assign imm_sx = {{(XLEN-IMM_W){ir_r[IMM_W-1]}}, ir_r[IMM_W-1:0]};
   assign imm_sh = imm_sx << 2;
   assign op_a   = alu_src_a ? a_r : pc_r;

   always_comb begin
      case (alu_src_b)
         SB_REG:    op_b = b_r;
         SB_FOUR:   op_b = word_t'(4);
         SB_IMM:    op_b = imm_sx;
         SB_IMM_SH: op_b = imm_sh;
         default:   op_b = b_r;
      endcase
   end

   mcdp_aluctl u_actl (
      .alu_op (alu_op),
      .funct  (ir_r[5:0]),
      .fn     (alu_fn)
   );

   mcdp_alu u_alu (
      .fn   (alu_fn),
      .a    (op_a),
      .b    (op_b),
      .y    (alu_y),
      .zero (alu_zero),
      .ovf  (alu_ovf)
   );

   // Next PC
   assign jump_tgt = {pc_r[31:28], ir_r[25:0], 2'b00};

   always_comb begin
      case (pc_src)
         PS_ALU:  pc_next = alu_y;
         PS_OUT:  pc_next = aluout_r;
         PS_JMP:  pc_next = jump_tgt;
         PS_VEC:  pc_next = EXC_VEC;
         default: pc_next = alu_y;
      endcase
   end

   assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

   // Holding registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_r     <= RESET_PC;
         ir_r     <= '0;
         mdr_r    <= '0;
         a_r      <= '0;
         b_r      <= '0;
         aluout_r <= '0;
         epc_r    <= '0;
         cause_r  <= '0;
      end else begin
         if (pc_en)    pc_r    <= pc_next;
         if (ir_wr)    ir_r    <= mem_word;
         if (mem_rd)   mdr_r   <= mem_word;
         if (epc_wr)   epc_r   <= alu_y;
         if (cause_wr) cause_r <= {{(XLEN-1){1'b0}}, int_cause};
         a_r      <= rf_a;
         b_r      <= rf_b;
         aluout_r <= alu_y;
      end
   end

   assign opcode    = ir_r[31:26];
   assign funct     = ir_r[5:0];
   assign pc_o      = pc_r;
   assign aluout_o  = aluout_r;
   assign mem_rdata = mem_word;
   assign epc_o     = epc_r;
   assign cause_o   = cause_r;

   // Checks on the datapath
   a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_r));

   a_r9_vector_target: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && pc_src == PS_VEC) |=> (pc_r == EXC_VEC));

   a_r3_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_wr |=> $stable(ir_r));

   a_r12_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
      cause_wr |=> (cause_r == {{(XLEN-1){1'b0}}, $past(int_cause)}));

   a_r6_ovf_only_arith: assert property (@(posedge clk) disable iff (!rst_n)
      alu_ovf |-> (alu_fn == FN_ADD || alu_fn == FN_SUB));

   wire unused_ok = addr_unused;
endmodule

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
   localparam int unsigned MAW = 6;

   typedef struct packed {
      logic       iord, mrd, mwr, irw, rdst, m2r, rwr, srca;
      logic [1:0] srcb, aop, psrc;
      logic       pcw, pcwc, epcw, causew, icause;
   } ctl_t;

   typedef struct packed {
      ctl_t        c;
      logic [31:0] pc;
      logic        chk;
      logic [31:0] alu;
      logic        ovf;
      logic        chk_rd;
      logic [31:0] rd;
   } vec_t;

   localparam ctl_t C_FETCH = '{mrd:1'b1, irw:1'b1, srcb:2'b01, pcw:1'b1, default:'0};
   localparam ctl_t C_DEC   = '{srcb:2'b11, default:'0};
   localparam ctl_t C_MADR  = '{srca:1'b1, srcb:2'b10, default:'0};
   localparam ctl_t C_MRD   = '{iord:1'b1, mrd:1'b1, default:'0};
   localparam ctl_t C_WB    = '{rwr:1'b1, m2r:1'b1, default:'0};
   localparam ctl_t C_MWR   = '{iord:1'b1, mwr:1'b1, default:'0};
   localparam ctl_t C_EXE   = '{srca:1'b1, aop:2'b10, default:'0};
   localparam ctl_t C_RC    = '{rdst:1'b1, rwr:1'b1, default:'0};
   localparam ctl_t C_BR    = '{srca:1'b1, aop:2'b01, pcwc:1'b1, psrc:2'b01, default:'0};
   localparam ctl_t C_JMP   = '{pcw:1'b1, psrc:2'b10, default:'0};
   localparam ctl_t C_EXC   = '{srcb:2'b01, aop:2'b01, pcw:1'b1, psrc:2'b11, epcw:1'b1,
                                causew:1'b1, icause:1'b1, default:'0};
   localparam ctl_t C_EPC0  = '{srcb:2'b01, aop:2'b01, epcw:1'b1, causew:1'b1, default:'0};

   localparam int NV = 61;
   localparam vec_t VEC [NV] = '{
      // lw r1, 64(r0)
      '{C_FETCH, 32'h4, 1'b1, 32'h4,   1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h4, 1'b1, 32'h104, 1'b0, 1'b0, 32'h0},
      '{C_MADR,  32'h4, 1'b1, 32'h40,  1'b0, 1'b0, 32'h0},
      '{C_MRD,   32'h4, 1'b0, 32'h0,   1'b0, 1'b1, 32'h5},
      '{C_WB,    32'h4, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0},
      // lw r2, 68(r0)
      '{C_FETCH, 32'h8, 1'b1, 32'h8,   1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h8, 1'b1, 32'h118, 1'b0, 1'b0, 32'h0},
      '{C_MADR,  32'h8, 1'b1, 32'h44,  1'b0, 1'b0, 32'h0},
      '{C_MRD,   32'h8, 1'b0, 32'h0,   1'b0, 1'b1, 32'h7},
      '{C_WB,    32'h8, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0},
      // add r3, r1, r2
      '{C_FETCH, 32'hC, 1'b1, 32'hC,    1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'hC, 1'b1, 32'h608C, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'hC, 1'b1, 32'hC,    1'b0, 1'b0, 32'h0},
      '{C_RC,    32'hC, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},
      // sw r3, 72(r0)
      '{C_FETCH, 32'h10, 1'b1, 32'h10,  1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h10, 1'b1, 32'h130, 1'b0, 1'b0, 32'h0},
      '{C_MADR,  32'h10, 1'b1, 32'h48,  1'b0, 1'b0, 32'h0},
      '{C_MWR,   32'h10, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0},
      // beq r1, r1, +2 (taken)
      '{C_FETCH, 32'h14, 1'b1, 32'h14, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h14, 1'b1, 32'h1C, 1'b0, 1'b0, 32'h0},
      '{C_BR,    32'h1C, 1'b1, 32'h0,  1'b0, 1'b0, 32'h0},
      // j word 9
      '{C_FETCH, 32'h20, 1'b1, 32'h20, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h20, 1'b1, 32'h44, 1'b0, 1'b0, 32'h0},
      '{C_JMP,   32'h24, 1'b0, 32'h0,  1'b0, 1'b0, 32'h0},
      // lw r4, 72(r0): reads back the stored sum
      '{C_FETCH, 32'h28, 1'b1, 32'h28,  1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h28, 1'b1, 32'h148, 1'b0, 1'b0, 32'h0},
      '{C_MADR,  32'h28, 1'b1, 32'h48,  1'b0, 1'b0, 32'h0},
      '{C_MRD,   32'h28, 1'b0, 32'h0,   1'b0, 1'b1, 32'hC},
      '{C_WB,    32'h28, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0},
      // add r0, r1, r2 (write discarded)
      '{C_FETCH, 32'h2C, 1'b1, 32'h2C, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h2C, 1'b1, 32'hAC, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h2C, 1'b1, 32'hC,  1'b0, 1'b0, 32'h0},
      '{C_RC,    32'h2C, 1'b0, 32'h0,  1'b0, 1'b0, 32'h0},
      // add r5, r0, r1 (r0 still zero)
      '{C_FETCH, 32'h30, 1'b1, 32'h30,   1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h30, 1'b1, 32'hA0B0, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h30, 1'b1, 32'h5,    1'b0, 1'b0, 32'h0},
      '{C_RC,    32'h30, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0},
      // lw r6, 76(r0)
      '{C_FETCH, 32'h34, 1'b1, 32'h34,  1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h34, 1'b1, 32'h164, 1'b0, 1'b0, 32'h0},
      '{C_MADR,  32'h34, 1'b1, 32'h4C,  1'b0, 1'b0, 32'h0},
      '{C_MRD,   32'h34, 1'b0, 32'h0,   1'b0, 1'b1, 32'h7FFF_FFFF},
      '{C_WB,    32'h34, 1'b0, 32'h0,   1'b0, 1'b0, 32'h0},
      // add r7, r6, r6 overflows, then trap
      '{C_FETCH, 32'h38, 1'b1, 32'h38,          1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h38, 1'b1, 32'hE0B8,        1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h38, 1'b1, 32'hFFFF_FFFE,   1'b1, 1'b0, 32'h0},
      '{C_EXC,   32'h8000_0180, 1'b1, 32'h34,   1'b0, 1'b0, 32'h0},
      // slt r8, r1, r6 at the vector
      '{C_FETCH, 32'h8000_0184, 1'b1, 32'h8000_0184, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h8000_0184, 1'b1, 32'h8001_022C, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h8000_0184, 1'b1, 32'h1,         1'b0, 1'b0, 32'h0},
      '{C_RC,    32'h8000_0184, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
      // or r9, r1, r2
      '{C_FETCH, 32'h8000_0188, 1'b1, 32'h8000_0188, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h8000_0188, 1'b1, 32'h8001_221C, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h8000_0188, 1'b1, 32'h7,         1'b0, 1'b0, 32'h0},
      '{C_RC,    32'h8000_0188, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
      // and r10, r1, r2
      '{C_FETCH, 32'h8000_018C, 1'b1, 32'h8000_018C, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h8000_018C, 1'b1, 32'h8001_421C, 1'b0, 1'b0, 32'h0},
      '{C_EXE,   32'h8000_018C, 1'b1, 32'h5,         1'b0, 1'b0, 32'h0},
      '{C_RC,    32'h8000_018C, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
      // beq r1, r2, +5 (not taken)
      '{C_FETCH, 32'h8000_0190, 1'b1, 32'h8000_0190, 1'b0, 1'b0, 32'h0},
      '{C_DEC,   32'h8000_0190, 1'b1, 32'h8000_01A4, 1'b0, 1'b0, 32'h0},
      '{C_BR,    32'h8000_0190, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h0}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic pre_we;
   logic [MAW-1:0] pre_addr;
   logic [31:0] pre_wdata;
   ctl_t ctl;
   logic [5:0] opcode, funct;
   logic alu_zero, alu_ovf;
   logic [31:0] pc_o, aluout_o, mem_rdata, epc_o, cause_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   mc_datapath #(.MEM_WORDS(64)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pre_we     (pre_we),
      .pre_addr   (pre_addr),
      .pre_wdata  (pre_wdata),
      .i_or_d     (ctl.iord),
      .mem_rd     (ctl.mrd),
      .mem_wr     (ctl.mwr),
      .ir_wr      (ctl.irw),
      .reg_dst    (ctl.rdst),
      .mem_to_reg (ctl.m2r),
      .reg_wr     (ctl.rwr),
      .alu_src_a  (ctl.srca),
      .alu_src_b  (ctl.srcb),
      .alu_op     (ctl.aop),
      .pc_src     (ctl.psrc),
      .pc_wr      (ctl.pcw),
      .pc_wr_cond (ctl.pcwc),
      .epc_wr     (ctl.epcw),
      .cause_wr   (ctl.causew),
      .int_cause  (ctl.icause),
      .opcode     (opcode),
      .funct      (funct),
      .alu_zero   (alu_zero),
      .alu_ovf    (alu_ovf),
      .pc_o       (pc_o),
      .aluout_o   (aluout_o),
      .mem_rdata  (mem_rdata),
      .epc_o      (epc_o),
      .cause_o    (cause_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_word(input int idx, input logic [31:0] w);
      @(negedge clk);
      pre_we    = 1'b1;
      pre_addr  = MAW'(idx);
      pre_wdata = w;
      @(negedge clk);
      pre_we    = 1'b0;
   endtask

   // Drive one control word at a falling edge, sample the live flags and
   // memory data before the rising edge, and return at the next falling edge.
   task automatic run_step(input ctl_t c, output logic ovf_s, output logic [31:0] rd_s);
      ctl = c;
      #1;
      ovf_s = alu_ovf;
      rd_s  = mem_rdata;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic        ovf_s;
      logic [31:0] rd_s;
      rst_n     = 1'b0;
      pre_we    = 1'b0;
      pre_addr  = '0;
      pre_wdata = '0;
      ctl       = '0;

      load_word(0,  32'h8C01_0040);
      load_word(1,  32'h8C02_0044);
      load_word(2,  32'h0022_1820);
      load_word(3,  32'hAC03_0048);
      load_word(4,  32'h1021_0002);
      load_word(5,  32'hFFFF_FFFF);
      load_word(7,  32'h0800_0009);
      load_word(9,  32'h8C04_0048);
      load_word(10, 32'h0022_0020);
      load_word(11, 32'h0001_2820);
      load_word(12, 32'h8C06_004C);
      load_word(13, 32'h00C6_3820);
      load_word(16, 32'h0000_0005);
      load_word(17, 32'h0000_0007);
      load_word(18, 32'h0000_0000);
      load_word(19, 32'h7FFF_FFFF);
      load_word(32, 32'h0026_402A);
      load_word(33, 32'h0022_4825);
      load_word(34, 32'h0022_5024);
      load_word(35, 32'h1022_0005);

      // R1: reset values
      @(negedge clk);
      check("R1 pc", pc_o, 32'h0);
      check("R1 aluout", aluout_o, 32'h0);
      check("R1 epc", epc_o, 32'h0);
      check("R1 cause", cause_o, 32'h0);
      // R2: preloaded word visible through the PC-addressed port
      #1;
      check("R2 preload read", mem_rdata, 32'h8C01_0040);

      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run_step(VEC[i].c, ovf_s, rd_s);
         check($sformatf("R8 R9 pc step %0d", i), pc_o, VEC[i].pc);
         if (VEC[i].chk) begin
            check($sformatf("R4 R5 R7 R10 aluout step %0d", i), aluout_o, VEC[i].alu);
            check($sformatf("R6 ovf step %0d", i), {31'b0, ovf_s}, {31'b0, VEC[i].ovf});
         end
         if (VEC[i].chk_rd)
            check($sformatf("R2 R11 mem read step %0d", i), rd_s, VEC[i].rd);
      end

      // R3: fields of the held branch instruction
      check("R3 opcode", {26'b0, opcode}, 32'h4);
      check("R3 funct", {26'b0, funct}, 32'h5);
      // R12: trap captured the faulting address and overflow code
      check("R12 epc after trap", epc_o, 32'h34);
      check("R12 cause after trap", cause_o, 32'h1);

      // R12 with code 0 and no PC write; R8 PC holds; R3 IR holds
      run_step(C_EPC0, ovf_s, rd_s);
      check("R12 epc second write", epc_o, 32'h8000_018C);
      check("R12 cause code 0", cause_o, 32'h0);
      check("R8 pc held", pc_o, 32'h8000_0190);
      check("R3 opcode held", {26'b0, opcode}, 32'h4);

      ctl = '0;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule